// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware part of taking an external interrupt in a 32-bit core that has a user mode and a kernel mode. When a request arrives with an 8-bit vector number and interrupts are enabled, the block captures a snapshot of the core state. It then issues one register-file write per cycle to:

- clear the user-mode flag,
- replace the status word with its shifted form,
- exchange the stack pointers when the interrupted code ran in user mode,
- record the return address, the exception status and the exception data address.

After the writes it reads the handler address from a vector table in memory and writes it into the program counter. A failed table read skips the PC write and raises a fault alongside the completion pulse.

The core sees the block through four paths:

- a request/vector input;
- a set of register-file read values, sampled once at acceptance;
- a single register write port with a 3-bit target select;
- a memory read port that answers with data or an error.

Requests that arrive while a sequence is running are dropped.

Top module: `irq_entry_seq`

## Requirements
- R1: A request while `intEnable` is 0 is ignored: no register write, no memory request, no `done`.
- R2: The status word written (target code 1) equals `((old << 10) & 32'h3FFF_FFFF) | (old & 32'h8000_0000)`, where `old` is the status sampled at acceptance.
- R3: The first write of every accepted sequence goes to target code 0 (the user-mode flag) with data 0, in the cycle after acceptance.
- R4: If the user-mode input was 1 at acceptance, the sequence writes the sampled stack pointer to the user stack pointer (code 2) and then the sampled kernel stack pointer to the stack pointer (code 3). From kernel mode both writes are omitted.
- R5: The sequence ends its save phase with these three writes, in this order:
  - the sampled PC to the exception return register (code 4);
  - `vector*256` to the exception status register (code 5);
  - 0 to the exception data address register (code 6).
- R6: The write order is fixed at 0, 1, [2, 3], 4, 5, 6, then a memory read at `excBase + vector*4`. Read data is little-endian: `memRdData[7:0]` is the byte at the address and `memRdData[31:24]` the byte at address+3. On success the 32-bit value is written to the PC (code 7).
- R7: If the table read returns `memRdErr`, no PC write occurs and `fault` is 1 in the same cycle as `done`.
- R8: `done` is a one-cycle pulse that closes each accepted sequence. Requests arriving between acceptance and the cycle after `done` start no new sequence.
- R9: The vector and all register inputs are captured at acceptance. Later changes to them do not alter the sequence in progress.
- R10: After reset, `regWrEn`, `memReq`, `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqReq | input | 1 | Interrupt request |
| irqVector | input | 8 | Vector number of the request |
| intEnable | input | 1 | Interrupt-enable flag of the core |
| userMode | input | 1 | Core currently in user mode |
| curStatus | input | 32 | Current status word |
| curSp | input | 32 | Current stack pointer |
| kernelSp | input | 32 | Saved kernel stack pointer |
| curPc | input | 32 | Return address (current PC) |
| excBase | input | 32 | Exception vector table base |
| regWrEn | output | 1 | Register write strobe |
| regWrSel | output | 3 | Write target (0 user flag, 1 status, 2 user SP, 3 SP, 4 return reg, 5 exc status, 6 exc data addr, 7 PC) |
| regWrData | output | 32 | Write data |
| memReq | output | 1 | Vector table read request, held until answered |
| memAddr | output | 32 | Vector table read address |
| memRdValid | input | 1 | Read response valid |
| memRdErr | input | 1 | Read response is an error |
| memRdData | input | 32 | Read data, little-endian byte lanes |
| done | output | 1 | Sequence complete pulse |
| fault | output | 1 | Vector read failed (with done) |

## Verification
The case that is hardest to reach from the ports is a second request landing while the sequence runs. It must neither restart the sequence nor leak its vector into the writes. The bench raises the request again with a different vector in the middle of the save phase and drops it before `done`. It then checks that exactly one write list appears and that the exception status carries the first vector. Latching is covered in the same way: every vector-table run changes the vector and the register inputs right after acceptance, and the expected writes are built from the values sampled at acceptance. A run with an error response and a run from kernel mode cover the two branches that remove writes from the list.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    WR_UFLAG  = 3'd0,
    WR_STATUS = 3'd1,
    WR_USP    = 3'd2,
    WR_SP     = 3'd3,
    WR_RETADR = 3'd4,
    WR_EXSTAT = 3'd5,
    WR_EXDADR = 3'd6,
    WR_PC     = 3'd7
  } wrSel_e;

  typedef struct packed {
    logic   capture;
    logic   wrEn;
    wrSel_e wrSel;
    logic   memReq;
    logic   setFault;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqReq,
  input  logic      intEnable,
  input  logic      wasUser,
  input  logic      memRdValid,
  input  logic      memRdErr,
  output ctrlStrb_t strb,
  output logic      seqDone,
  output logic      isIdle
);
  typedef enum logic [2:0] {ST_IDLE, ST_SAVE, ST_FETCH, ST_LOADPC, ST_DONE} state_e;

  state_e state, stateNxt;
  wrSel_e step, stepNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= WR_UFLAG;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    stepNxt  = step;
    strb     = '0;
    strb.wrSel = WR_UFLAG;
    unique case (state)
      ST_IDLE: begin
        if (irqReq && intEnable) begin
          strb.capture = 1'b1;
          stateNxt     = ST_SAVE;
          stepNxt      = WR_UFLAG;
        end
      end
      ST_SAVE: begin
        strb.wrEn  = 1'b1;
        strb.wrSel = step;
        if (step == WR_EXDADR) begin
          stateNxt = ST_FETCH;
        end else if (step == WR_STATUS && !wasUser) begin
          stepNxt = WR_RETADR;
        end else begin
          stepNxt = wrSel_e'(step + 3'd1);
        end
      end
      ST_FETCH: begin
        strb.memReq = 1'b1;
        if (memRdValid) begin
          if (memRdErr) begin
            strb.setFault = 1'b1;
            stateNxt      = ST_DONE;
          end else begin
            stateNxt = ST_LOADPC;
          end
        end
      end
      ST_LOADPC: begin
        strb.wrEn  = 1'b1;
        strb.wrSel = WR_PC;
        stateNxt   = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign seqDone = (state == ST_DONE);
  assign isIdle  = (state == ST_IDLE);
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int VEC_W        = 8,
  parameter int STATUS_SHIFT = 10,
  parameter int EXS_SHIFT    = 8,
  parameter int SLOT_SHIFT   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             userMode,
  input  logic [XLEN-1:0]  curStatus,
  input  logic [XLEN-1:0]  curSp,
  input  logic [XLEN-1:0]  kernelSp,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  excBase,
  input  logic [XLEN-1:0]  memRdData,
  output logic             wasUser,
  output logic             faultFlag,
  output logic [XLEN-1:0]  wrData,
  output logic [XLEN-1:0]  memAddr
);
  localparam int LOW_W = XLEN - 2;

  logic [VEC_W-1:0] vecQ;
  logic [XLEN-1:0]  statusQ, spQ, kspQ, pcQ, baseQ, handlerQ;
  logic [XLEN-1:0]  shifted, newStatus, vecWide, handlerLe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= '0; statusQ <= '0; spQ <= '0; kspQ <= '0;
      pcQ <= '0; baseQ <= '0; wasUser <= 1'b0; faultFlag <= 1'b0;
      handlerQ <= '0;
    end else begin
      if (strb.capture) begin
        vecQ      <= irqVector;
        statusQ   <= curStatus;
        spQ       <= curSp;
        kspQ      <= kernelSp;
        pcQ       <= curPc;
        baseQ     <= excBase;
        wasUser   <= userMode;
        faultFlag <= 1'b0;
      end
      if (strb.setFault) faultFlag <= 1'b1;
      if (strb.memReq) handlerQ <= handlerLe;
    end
  end

  // Byte lane 0 holds the lowest address; assemble the word lane by lane.
  for (genvar b = 0; b < XLEN / 8; b++) begin : g_lane
    assign handlerLe[8*b +: 8] = memRdData[8*b +: 8];
  end

  assign shifted   = statusQ << STATUS_SHIFT;
  assign newStatus = {statusQ[XLEN-1], 1'b0, shifted[LOW_W-1:0]};
  assign vecWide   = {{(XLEN-VEC_W){1'b0}}, vecQ};
  assign memAddr   = baseQ + (vecWide << SLOT_SHIFT);

  always_comb begin
    unique case (strb.wrSel)
      WR_UFLAG:  wrData = '0;
      WR_STATUS: wrData = newStatus;
      WR_USP:    wrData = spQ;
      WR_SP:     wrData = kspQ;
      WR_RETADR: wrData = pcQ;
      WR_EXSTAT: wrData = vecWide << EXS_SHIFT;
      WR_EXDADR: wrData = '0;
      WR_PC:     wrData = handlerQ;
      default:   wrData = '0;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             intEnable,
  input  logic             userMode,
  input  logic [XLEN-1:0]  curStatus,
  input  logic [XLEN-1:0]  curSp,
  input  logic [XLEN-1:0]  kernelSp,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  excBase,
  output logic             regWrEn,
  output logic [2:0]       regWrSel,
  output logic [XLEN-1:0]  regWrData,
  output logic             memReq,
  output logic [XLEN-1:0]  memAddr,
  input  logic             memRdValid,
  input  logic             memRdErr,
  input  logic [XLEN-1:0]  memRdData,
  output logic             done,
  output logic             fault
);
  ctrlStrb_t strb;
  logic wasUser, faultFlag, seqDone, isIdle;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .intEnable(intEnable),
    .wasUser(wasUser), .memRdValid(memRdValid), .memRdErr(memRdErr),
    .strb(strb), .seqDone(seqDone), .isIdle(isIdle)
  );

  irq_entry_dp #(.XLEN(XLEN), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqVector(irqVector),
    .userMode(userMode), .curStatus(curStatus), .curSp(curSp),
    .kernelSp(kernelSp), .curPc(curPc), .excBase(excBase),
    .memRdData(memRdData), .wasUser(wasUser), .faultFlag(faultFlag),
    .wrData(regWrData), .memAddr(memAddr)
  );

  assign regWrEn  = strb.wrEn;
  assign regWrSel = strb.wrSel;
  assign memReq   = strb.memReq;
  assign done     = seqDone;
  assign fault    = seqDone & faultFlag;
endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker (
  input logic        clk,
  input logic        rstN,
  input logic        irqReq,
  input logic        intEnable,
  input logic        isIdle,
  input logic        regWrEn,
  input logic [2:0]  regWrSel,
  input logic [31:0] regWrData,
  input logic        memReq,
  input logic        memRdValid,
  input logic        memRdErr,
  input logic        done,
  input logic        fault
);
  AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    isIdle && !intEnable |=> !regWrEn && !memReq && !done); // R1
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regWrSel == 3'd1 |-> regWrData[9:0] == 10'd0 && !regWrData[30]); // R2
  AST_UFLAG_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    isIdle && irqReq && intEnable |=> regWrEn && regWrSel == 3'd0 && regWrData == 32'd0); // R3
  AST_EXSTAT_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regWrSel == 3'd5 |-> regWrData[7:0] == 8'd0); // R5
  AST_NO_PC_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memRdValid && memRdErr |=> !regWrEn && done && fault); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done); // R7
  AST_NO_WRITE_IN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !regWrEn); // R6
endmodule

bind irq_entry_seq irq_entry_checker u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .intEnable(intEnable),
  .isIdle(isIdle), .regWrEn(regWrEn), .regWrSel(regWrSel),
  .regWrData(regWrData), .memReq(memReq), .memRdValid(memRdValid),
  .memRdErr(memRdErr), .done(done), .fault(fault)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 1'b0, intEnable = 1'b0, userMode = 1'b0;
  logic [7:0]  irqVector = '0;
  logic [31:0] curStatus = '0, curSp = '0, kernelSp = '0, curPc = '0, excBase = '0;
  logic        regWrEn, memReq, done, fault;
  logic [2:0]  regWrSel;
  logic [31:0] regWrData, memAddr;
  logic        memRdValid = 1'b0, memRdErr = 1'b0;
  logic [31:0] memRdData = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  irq_entry_seq dut (.*);

  typedef struct packed {
    logic [31:0] status; logic user; logic [31:0] sp; logic [31:0] ksp;
    logic [31:0] pc; logic [31:0] base; logic [7:0] vec;
    logic [31:0] handler; logic err;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h8000_1234, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h4000_0010, 32'h8000_0000, 8'd3,   32'h1234_5678, 1'b0},
    '{32'h0F0F_F0F0, 1'b0, 32'h0000_3000, 32'h0000_4000, 32'h4000_0100, 32'h0001_0000, 8'd255, 32'hCAFE_F00D, 1'b0},
    '{32'hFFFF_FFFF, 1'b1, 32'h0000_5000, 32'h0000_6000, 32'h4000_0204, 32'h0002_0000, 8'd0,   32'hDEAD_BEEF, 1'b1},
    '{32'h0000_0001, 1'b0, 32'h0000_7000, 32'h0000_8000, 32'h4000_0300, 32'h0003_0000, 8'd128, 32'h0403_0201, 1'b0}
  };

  // Write and memory monitors
  int          wrCnt = 0;
  logic [2:0]  logSel  [16];
  logic [31:0] logData [16];
  logic [31:0] seenAddr = '0;
  int          doneCnt = 0;
  logic        seenFault = 1'b0;
  vec_t        memCfg;

  always @(negedge clk) begin
    if (regWrEn && wrCnt < 16) begin
      logSel[wrCnt]  = regWrSel;
      logData[wrCnt] = regWrData;
    end
    if (regWrEn) wrCnt = wrCnt + 1;
    if (done) begin doneCnt = doneCnt + 1; seenFault = fault; end
    if (memReq && !memRdValid) begin
      seenAddr   = memAddr;
      memRdValid <= 1'b1;
      memRdErr   <= memCfg.err;
      memRdData  <= memCfg.err ? 32'h0 : memCfg.handler;
    end else begin
      memRdValid <= 1'b0;
      memRdErr   <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    wrCnt = 0; doneCnt = 0; seenFault = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #0.1;
      if (doneCnt > 0) begin ok = 1; break; end
    end
  endtask

  task automatic runVec(input vec_t v, input bit scramble);
    logic [2:0]  eSel  [16];
    logic [31:0] eData [16];
    int n = 0;
    bit ok;
    logic [31:0] expStatus;
    memCfg = v;
    @(negedge clk);
    clearLog();
    curStatus = v.status; userMode = v.user; curSp = v.sp; kernelSp = v.ksp;
    curPc = v.pc; excBase = v.base; irqVector = v.vec; intEnable = 1'b1;
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
    if (scramble) begin  // R9: inputs change after acceptance
      irqVector = ~v.vec; curSp = 32'h1111_1111; curPc = 32'h2222_2222;
      curStatus = 32'h3333_3333; excBase = 32'h4444_4440; userMode = ~v.user;
    end
    expStatus = ((v.status << 10) & 32'h3FFF_FFFF) | (v.status & 32'h8000_0000);
    eSel[n] = 3'd0; eData[n] = 32'd0;  n++;
    eSel[n] = 3'd1; eData[n] = expStatus; n++;
    if (v.user) begin
      eSel[n] = 3'd2; eData[n] = v.sp;  n++;
      eSel[n] = 3'd3; eData[n] = v.ksp; n++;
    end
    eSel[n] = 3'd4; eData[n] = v.pc; n++;
    eSel[n] = 3'd5; eData[n] = {16'd0, v.vec, 8'd0}; n++;
    eSel[n] = 3'd6; eData[n] = 32'd0; n++;
    if (!v.err) begin eSel[n] = 3'd7; eData[n] = v.handler; n++; end
    waitDone(ok);
    check(ok, "R8 done seen", {31'd0, ok}, 32'd1);
    check(wrCnt == n, "R4/R7 write count", wrCnt, n);
    for (int i = 0; i < n && i < wrCnt; i++) begin
      check(logSel[i] == eSel[i], "R6 write order", {29'd0, logSel[i]}, {29'd0, eSel[i]});
      case (eSel[i])
        3'd0: check(logData[i] == eData[i], "R3 user flag clear", logData[i], eData[i]);
        3'd1: check(logData[i] == eData[i], "R2 status", logData[i], eData[i]);
        3'd2, 3'd3: check(logData[i] == eData[i], "R4 stack swap", logData[i], eData[i]);
        3'd7: check(logData[i] == eData[i], "R6 handler to pc", logData[i], eData[i]);
        default: check(logData[i] == eData[i], "R5 save regs", logData[i], eData[i]);
      endcase
    end
    check(seenAddr == v.base + {22'd0, v.vec, 2'd0}, "R6 table address", seenAddr, v.base + {22'd0, v.vec, 2'd0});
    check(seenFault == v.err, "R7 fault", {31'd0, seenFault}, {31'd0, v.err});
    @(negedge clk);
    check(!done, "R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!regWrEn && !memReq && !done && !fault, "R10 reset outputs",
          {28'd0, regWrEn, memReq, done, fault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk
    for (int k = 0; k < 4; k++) runVec(VECS[k], 1'b1);

    // R9: scrambling vs none gives same result
    runVec(VECS[0], 1'b0);

    // R1: disabled request ignored
    @(negedge clk);
    clearLog();
    intEnable = 1'b0; irqReq = 1'b1;
    repeat (8) @(negedge clk);
    irqReq = 1'b0;
    #0.1;
    check(wrCnt == 0 && doneCnt == 0, "R1 disabled ignored", wrCnt + doneCnt, 32'd0);

    // R8: request during busy dropped
    memCfg = VECS[1];
    @(negedge clk);
    clearLog();
    intEnable = 1'b1; userMode = 1'b0; irqVector = 8'd5; excBase = 32'h0;
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
    @(negedge clk);
    irqVector = 8'd9; irqReq = 1'b1;
    repeat (3) @(negedge clk);
    irqReq = 1'b0;
    repeat (15) @(negedge clk);
    #0.1;
    check(doneCnt == 1, "R8 single sequence", doneCnt, 32'd1);
    check(wrCnt == 6, "R8 single write list", wrCnt, 32'd6);
    check(logData[3] == 32'h0000_0500, "R8 first vector kept", logData[3], 32'h0000_0500);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule